// File: doc/BRIEF.md
# Standby refresh sequencer for a pseudo-static RAM

This block is the refresh control logic that sits inside a pseudo-static memory device. It watches the active-low chip enable and a second active-low pin that has two jobs. While the chip is enabled, that pin is an output enable and the refresh logic ignores it. While the chip is in standby, the same pin is a refresh command. Both inputs pass through a two-stage synchroniser. Every width in this block is counted in synchronised clock cycles.

In standby, the block measures each low pulse on the command pin with a cycle counter.
- A pulse shorter than `MIN_LOW_CYC` is an incomplete refresh. It raises a sticky error flag and refreshes nothing.
- A pulse of medium width requests exactly one automatic refresh.
- A low level held for `SELF_ENTRY_CYC` cycles puts the block into self refresh. Refreshes are then paced by an internal timer, one every `SELF_PERIOD_CYC` cycles.

Each refresh produces a one-cycle strobe and advances an internal row counter, which wraps from the last row back to zero. When the pin rises to leave self refresh, a recovery window of `RECOVER_CYC` cycles follows. During that window both pins must stay high.

The controller has six states:
- `SQ_DISARMED`: standby, but the command pin has not yet been seen high. This is also the state after reset.
- `SQ_ARMED`: standby, with the pin high.
- `SQ_MEASURE`: the pin is low and its width is being counted.
- `SQ_SELF`: self refresh.
- `SQ_RECOVER`: the recovery window after self refresh.
- `SQ_ACTIVE`: the chip is enabled.

Its transitions are:
- `SQ_DISARMED` goes to `SQ_ARMED` when the pin goes high.
- `SQ_ARMED` goes to `SQ_MEASURE` when the pin falls.
- `SQ_MEASURE` goes back to `SQ_ARMED` when the pin rises, issuing one refresh or flagging a short pulse.
- `SQ_MEASURE` goes to `SQ_SELF` when the width threshold is reached.
- `SQ_SELF` goes to `SQ_RECOVER` when the pin rises.
- `SQ_RECOVER` goes to `SQ_ARMED` when the window expires cleanly.
- `SQ_RECOVER` goes to `SQ_DISARMED` or `SQ_ACTIVE` on a violation.
- Any standby state except `SQ_SELF` and `SQ_RECOVER` goes to `SQ_ACTIVE` when chip enable goes low.
- `SQ_ACTIVE` goes to `SQ_ARMED` or `SQ_DISARMED` when chip enable rises, depending on the pin level.

Top module: `standby_refresh_ctrl`

## Requirements
- R1: After reset, and whenever chip enable rises while the command pin is low, a low pin starts no refresh. The pin must first be seen high, and only a later falling edge starts one.
- R2: While chip enable is low, pulses on the command pin never produce a refresh strobe and never move the row counter.
- R3: A standby low pulse whose width w satisfies `MIN_LOW_CYC` <= w < `SELF_ENTRY_CYC` produces exactly one refresh strobe and advances the row by one.
- R4: A standby low pulse shorter than `MIN_LOW_CYC` produces no strobe and sets `short_err_o`.
- R5: A low level held for `SELF_ENTRY_CYC` cycles enters self refresh. `self_o` goes high, one strobe is issued on entry, and one more follows every `SELF_PERIOD_CYC` cycles until the pin rises.
- R6: `row_o` equals the number of refreshes since reset modulo `ROWS`, so it goes from `ROWS-1` to 0.
- R7: For `RECOVER_CYC` cycles after the pin rises out of self refresh, a pin fall or chip enable going low sets `recov_err_o`, and that fall starts no refresh.
- R8: Both error flags hold until `clr_err_i` is high on a clock edge, which clears them. A new error in the same cycle wins.
- R9: While `rst_n` is low, `row_o` is 0 and `refresh_stb_o`, `self_o`, `short_err_o` and `recov_err_o` are all 0.
- R10: Each refresh strobe is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| oe_rf_n_i | input | 1 | Shared output-enable / refresh command, active low, asynchronous |
| clr_err_i | input | 1 | Clears both error flags |
| row_o | output | ROW_W (11) | Row counter: the row most recently refreshed is `row_o - 1` |
| refresh_stb_o | output | 1 | One-cycle row-refresh strobe |
| self_o | output | 1 | High while in self refresh |
| short_err_o | output | 1 | Sticky flag for a too-short refresh pulse |
| recov_err_o | output | 1 | Sticky flag for a recovery-window violation |

## Verification
Pulse widths are fed in on either side of each threshold:
- one cycle and `MIN_LOW_CYC-1` check that too-short pulses are rejected;
- exactly `MIN_LOW_CYC` and `SELF_ENTRY_CYC-1` check that they are single refreshes;
- a long hold checks that it becomes self refresh with the expected number of timer-paced strobes.

Pin activity while the chip is enabled and a pin held low across chip-enable release show the difference between output-enable use and refresh, and test the arming rule. A fall during the recovery window must be flagged, never counted. A run of 2049 single refreshes shows the row counter wrapping.

// File: rtl/srq_pkg.sv
package srq_pkg;
    typedef enum logic [2:0] {
        SQ_ACTIVE,
        SQ_DISARMED,
        SQ_ARMED,
        SQ_MEASURE,
        SQ_SELF,
        SQ_RECOVER
    } sq_state_e;
endpackage

// File: rtl/srq_sync.sv
module srq_sync #(
    parameter int            W      = 2,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srq_tick.sv
module srq_tick #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (restart)        count <= '0;
        else if (count != '1)    count <= count + 1'b1;
    end
endmodule

// File: rtl/srq_rowctr.sv
module srq_rowctr #(
    parameter int ROWS  = 2048,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)        row <= '0;
        else if (adv)      row <= (row == LAST) ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/standby_refresh_ctrl.sv
module standby_refresh_ctrl
    import srq_pkg::*;
#(
    parameter int ROWS            = 2048,
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_LOW_CYC     = 16,
    parameter int SELF_ENTRY_CYC  = 1600,
    parameter int RECOVER_CYC     = 120,
    parameter int SELF_PERIOD_CYC = 3125
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n_i,
    input  logic                    oe_rf_n_i,
    input  logic                    clr_err_i,
    output logic [$clog2(ROWS)-1:0] row_o,
    output logic                    refresh_stb_o,
    output logic                    self_o,
    output logic                    short_err_o,
    output logic                    recov_err_o
);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int MAX_A   = (SELF_ENTRY_CYC > RECOVER_CYC) ? SELF_ENTRY_CYC : RECOVER_CYC;
    localparam int CNT_MAX = (MAX_A > SELF_PERIOD_CYC) ? MAX_A : SELF_PERIOD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(MIN_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] ENTRY_HIT = CNT_W'(SELF_ENTRY_CYC - 2);
    localparam logic [CNT_W-1:0] RECOV_HIT = CNT_W'(RECOVER_CYC - 1);
    localparam logic [CNT_W-1:0] TICK_HIT  = CNT_W'(SELF_PERIOD_CYC - 1);

    logic [1:0]       sync_q;
    logic             stby;
    logic             rf_hi;
    logic [CNT_W-1:0] cnt;
    sq_state_e        st_q, st_d;
    logic             restart, adv, set_short, set_recov;

    srq_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n_i, oe_rf_n_i}), .q(sync_q)
    );
    assign stby  = sync_q[1];
    assign rf_hi = sync_q[0];

    srq_tick #(.W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .count(cnt)
    );

    srq_rowctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(adv), .row(row_o)
    );

    // next-state and event decode
    always_comb begin
        st_d      = st_q;
        restart   = 1'b0;
        adv       = 1'b0;
        set_short = 1'b0;
        set_recov = 1'b0;
        unique case (st_q)
            SQ_ACTIVE: begin
                if (stby) st_d = rf_hi ? SQ_ARMED : SQ_DISARMED;
            end
            SQ_DISARMED: begin
                if (!stby)      st_d = SQ_ACTIVE;
                else if (rf_hi) st_d = SQ_ARMED;
            end
            SQ_ARMED: begin
                if (!stby) st_d = SQ_ACTIVE;
                else if (!rf_hi) begin
                    st_d    = SQ_MEASURE;
                    restart = 1'b1;
                end
            end
            SQ_MEASURE: begin
                if (!stby) st_d = SQ_ACTIVE;
                else if (rf_hi) begin
                    st_d = SQ_ARMED;
                    if (cnt < SHORT_LIM) set_short = 1'b1;
                    else                 adv       = 1'b1;
                end else if (cnt == ENTRY_HIT) begin
                    st_d    = SQ_SELF;
                    adv     = 1'b1;
                    restart = 1'b1;
                end
            end
            SQ_SELF: begin
                if (rf_hi) begin
                    st_d    = SQ_RECOVER;
                    restart = 1'b1;
                end else if (cnt == TICK_HIT) begin
                    adv     = 1'b1;
                    restart = 1'b1;
                end
            end
            SQ_RECOVER: begin
                if (!stby || !rf_hi) begin
                    set_recov = 1'b1;
                    st_d      = !stby ? SQ_ACTIVE : SQ_DISARMED;
                end else if (cnt == RECOV_HIT) begin
                    st_d = SQ_ARMED;
                end
            end
            default: st_d = SQ_DISARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_DISARMED;
        else        st_q <= st_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_stb_o <= 1'b0;
            self_o        <= 1'b0;
            short_err_o   <= 1'b0;
            recov_err_o   <= 1'b0;
        end else begin
            refresh_stb_o <= adv;
            self_o        <= (st_d == SQ_SELF);
            short_err_o   <= set_short | (short_err_o & ~clr_err_i);
            recov_err_o   <= set_recov | (recov_err_o & ~clr_err_i);
        end
    end

    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb_o |=> !refresh_stb_o);

    // R2
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb_o |-> ($past(st_q) == SQ_MEASURE || $past(st_q) == SQ_SELF));

    // R6
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb_o |-> (row_o == (($past(row_o) == ROW_W'(ROWS - 1)) ? '0
                                     : $past(row_o) + 1'b1)));

    // R5
    self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_o) |-> !$past(rf_hi));

    // R4
    short_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_err_o) |-> $past(st_q) == SQ_MEASURE);

    // R7
    recov_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recov_err_o) |-> $past(st_q) == SQ_RECOVER);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_err_o && !clr_err_i) |=> short_err_o);
endmodule

// File: tb/standby_refresh_ctrl_test.sv
`timescale 1ns/1ps
module standby_refresh_ctrl_test;
    localparam int ROWS = 2048;
    localparam int MINW = 4;
    localparam int LONG = 40;
    localparam int RECV = 12;
    localparam int PER  = 60;
    localparam int NV   = 7;
    localparam int VW  [NV] = '{10, 4, 3, 39, 1, 25, 190};
    localparam int VG  [NV] = '{20, 20, 20, 20, 20, 20, 30};
    localparam int VS  [NV] = '{1, 1, 0, 1, 0, 1, 3};
    localparam int VE  [NV] = '{0, 0, 1, 0, 1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic rf_n = 1'b1;
    logic clr = 1'b0;
    logic [10:0] row;
    logic stb, self_m, serr, rerr;
    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    int exp_row = 0;
    int base;

    always #2.5 clk = ~clk;

    standby_refresh_ctrl #(
        .ROWS(ROWS), .SYNC_STAGES(2), .MIN_LOW_CYC(MINW),
        .SELF_ENTRY_CYC(LONG), .RECOVER_CYC(RECV), .SELF_PERIOD_CYC(PER)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_rf_n_i(rf_n),
        .clr_err_i(clr), .row_o(row), .refresh_stb_o(stb), .self_o(self_m),
        .short_err_o(serr), .recov_err_o(rerr)
    );

    always @(posedge clk) if (stb) stb_cnt <= stb_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int w, input int gap);
        rf_n = 1'b0;
        wait_cyc(w);
        rf_n = 1'b1;
        wait_cyc(gap);
    endtask

    task automatic clear_flags();
        clr = 1'b1;
        wait_cyc(1);
        clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(4);
        // R9 reset state
        check("R9 row", int'(row), 0);
        check("R9 flags", int'({stb, self_m, serr, rerr}), 0);
        rf_n = 1'b0;
        rst_n = 1'b1;
        // R1: pin low out of reset must not refresh
        base = stb_cnt;
        wait_cyc(30);
        rf_n = 1'b1;
        wait_cyc(10);
        check("R1 low after reset", stb_cnt - base, 0);

        // table of width vectors: R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            base = stb_cnt;
            pulse(VW[i], VG[i]);
            exp_row = (exp_row + VS[i]) % ROWS;
            check("R3/R4/R5/R10 strobes", stb_cnt - base, VS[i]);
            check("R4 short flag", int'(serr), VE[i]);
            check("R6 row", int'(row), exp_row);
            if (VE[i] != 0) begin
                clear_flags();
                check("R8 clear", int'(serr), 0);
            end
        end

        // R5 self flag during and after
        rf_n = 1'b0;
        wait_cyc(LONG + 10);
        check("R5 self high", int'(self_m), 1);
        rf_n = 1'b1;
        wait_cyc(RECV + 10);
        check("R5 self low", int'(self_m), 0);
        exp_row = (exp_row + 1) % ROWS;
        check("R5 entry strobe row", int'(row), exp_row);

        // R2: pin pulses while enabled
        ce_n = 1'b0;
        wait_cyc(4);
        base = stb_cnt;
        for (int k = 0; k < 3; k++) pulse(10, 5);
        pulse(LONG + 20, 5);
        check("R2 no strobe", stb_cnt - base, 0);
        check("R2 row", int'(row), exp_row);

        // R1: chip enable released with pin low
        rf_n = 1'b0;
        wait_cyc(5);
        ce_n = 1'b1;
        base = stb_cnt;
        wait_cyc(LONG + 20);
        rf_n = 1'b1;
        wait_cyc(10);
        check("R1 disarmed", stb_cnt - base, 0);
        check("R1 not self", int'(self_m), 0);
        base = stb_cnt;
        pulse(8, 20);
        check("R1 armed", stb_cnt - base, 1);
        exp_row = (exp_row + 1) % ROWS;

        // R7: fall inside recovery window
        base = stb_cnt;
        rf_n = 1'b0;
        wait_cyc(LONG + 20);
        rf_n = 1'b1;
        wait_cyc(4);
        rf_n = 1'b0;
        wait_cyc(20);
        rf_n = 1'b1;
        wait_cyc(20);
        exp_row = (exp_row + 1) % ROWS;
        check("R7 only entry strobe", stb_cnt - base, 1);
        check("R7 flag", int'(rerr), 1);
        wait_cyc(5);
        check("R8 sticky", int'(rerr), 1);
        clear_flags();
        check("R8 cleared", int'(rerr), 0);
        check("R7 row", int'(row), exp_row);

        // R6 wrap: fresh reset then 2049 refreshes
        rst_n = 1'b0;
        wait_cyc(3);
        check("R9 row after reset", int'(row), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        base = stb_cnt;
        for (int k = 0; k < ROWS; k++) pulse(5, 4);
        wait_cyc(4);
        check("R6 wrap to zero", int'(row), 0);
        pulse(5, 10);
        check("R6 after wrap", int'(row), 1);
        check("R3 count", stb_cnt - base, ROWS + 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule